// File: doc/BRIEF.md
# Flash Host Power-Up and Ready Sequencer

This block sits on the host side of a serial flash and decides when the rest of the system may talk to it. Once a supply-good input goes high it counts system-clock cycles and opens two permissions in turn: a read permit after a short select delay, and later a write permit after a much longer delay. Program and erase commands need the write permit. Both delays are given in nanoseconds and converted to cycles at elaboration, rounding up.

Operations are requested one at a time through a request/grant handshake. The requester holds the grant while it issues its command bytes through its own SPI master, then pulses a done input. After a program or erase, the block does not wait for a fixed time. It drives a one-cycle start pulse and a status-read opcode to the SPI master, reads back one status byte, and repeats the read after a programmable gap until the ready bit is set. A cycle limit on the whole poll raises a sticky error flag if the device never reports ready. A loss of supply-good clears everything and restarts the power-up wait.

Top module: `fpwr_seq_top`

## Requirements
- R1: With supply_ok sampled high on N consecutive rising edges, rd_permit is 1 exactly when N >= SEL_CYC, where SEL_CYC = ceil(CLK_HZ * SEL_DELAY_NS / 1e9).
- R2: wr_permit is 1 exactly when N >= WR_CYC, where WR_CYC = ceil(CLK_HZ * WR_DELAY_NS / 1e9) and WR_CYC >= SEL_CYC.
- R3: While supply_ok is 0, rd_permit and wr_permit are 0. From the next rising edge on, op_grant, busy and tmo_err are 0, and no request is granted.
- R4: A request with op_is_write = 0 is granted only under rd_permit, and one with op_is_write = 1 only under wr_permit. op_grant rises on the edge after such a request is sampled and stays high until the edge that samples op_done.
- R5: When a write grant ends, busy rises on that same edge. spi_start then pulses for exactly one cycle, with spi_cmd equal to STATUS_CMD.
- R6: A status byte with bit 7 = 1 ends the poll and busy falls. With bit 7 = 0, the next spi_start comes exactly POLL_GAP cycles after the edge that sampled spi_done. A write whose device stays busy for k status reads therefore causes k + 1 status reads.
- R7: While busy is 1, no grant is given, whatever the request.
- R8: If the poll has not finished after TMO_CYC cycles of busy, busy falls and tmo_err is set. tmo_err stays set until supply_ok goes low.
- R9: A read grant ending with op_done starts no status poll and leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply above operating threshold |
| op_req | input | 1 | Operation request, held until granted |
| op_is_write | input | 1 | Requested operation is program or erase |
| op_grant | output | 1 | Requester owns the flash |
| op_done | input | 1 | One-cycle pulse: requester finished its command |
| rd_permit | output | 1 | Select delay has elapsed |
| wr_permit | output | 1 | Write delay has elapsed |
| busy | output | 1 | Status poll in progress |
| tmo_err | output | 1 | Device never reported ready (sticky) |
| spi_start | output | 1 | One-cycle start of a status-read transfer |
| spi_cmd | output | 8 | Opcode for the status-read transfer |
| spi_done | input | 1 | Status transfer finished, spi_rdata valid |
| spi_rdata | input | 8 | Status byte returned by the device |

## Verification
The hardest situations to reach are the poll timeout and a supply-good loss in the middle of a poll, because both need the device to stay busy for a long time. The bench's status model hands out a programmed number of not-ready bytes before a ready one. A large count produces the timeout. The bench then drops supply_ok mid-poll to check that busy, the sticky error and the permits all clear. Not-ready bytes carry random low bits, so only bit 7 can decide the outcome.

// File: rtl/fpwr_pkg.sv
package fpwr_pkg;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_ISSUE = 2'd1,
      PS_WAIT  = 2'd2,
      PS_GAP   = 2'd3
   } poll_state_t;

   // ceil(hz * ns / 1e9)
   function automatic longint unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
      return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/fpwr_wait_timer.sv
module fpwr_wait_timer #(
   parameter int unsigned LIMIT = 16,
   localparam int unsigned W = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   output logic [W-1:0] count,
   output logic         expired
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("fpwr_wait_timer: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         count <= '0;
      else if (count != W'(LIMIT))
         count <= count + 1'b1;
   end

   assign expired = run && (count == W'(LIMIT));

   a_r1_saturates : assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $past(count) == W'(LIMIT)) |-> count == W'(LIMIT));

endmodule

// File: rtl/fpwr_status_poll.sv
module fpwr_status_poll
   import fpwr_pkg::*;
#(
   parameter int unsigned GAP_CYC   = 4,
   parameter int unsigned TMO_CYC   = 1000,
   parameter int unsigned READY_BIT = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       start,
   input  logic       spi_done,
   input  logic [7:0] spi_rdata,
   output logic       spi_start,
   output logic       busy,
   output logic       tmo_err
);

   localparam int unsigned GW = $clog2(GAP_CYC + 1);
   localparam int unsigned TW = $clog2(TMO_CYC + 1);

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("fpwr_status_poll: GAP_CYC must be at least 1");
      end
      if (TMO_CYC < 4) begin : g_bad_tmo
         $error("fpwr_status_poll: TMO_CYC must be at least 4");
      end
      if (READY_BIT > 7) begin : g_bad_bit
         $error("fpwr_status_poll: READY_BIT must lie within the status byte");
      end
   endgenerate

   poll_state_t    st;
   logic [GW-1:0]  gap_cnt;
   logic [TW-1:0]  tmo_cnt;
   logic           tmo_hit;

   assign tmo_hit = (st != PS_IDLE) && (tmo_cnt == TW'(TMO_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         st      <= PS_IDLE;
         gap_cnt <= '0;
         tmo_cnt <= '0;
         tmo_err <= 1'b0;
      end else if (tmo_hit) begin
         st      <= PS_IDLE;
         tmo_err <= 1'b1;
      end else begin
         if (st != PS_IDLE)
            tmo_cnt <= tmo_cnt + 1'b1;
         case (st)
            PS_IDLE: if (start) begin
               st      <= PS_ISSUE;
               tmo_cnt <= '0;
            end
            PS_ISSUE: st <= PS_WAIT;
            PS_WAIT: if (spi_done) begin
               if (spi_rdata[READY_BIT]) begin
                  st <= PS_IDLE;
               end else begin
                  st      <= PS_GAP;
                  gap_cnt <= '0;
               end
            end
            PS_GAP: begin
               if (gap_cnt == GW'(GAP_CYC - 1))
                  st <= PS_ISSUE;
               else
                  gap_cnt <= gap_cnt + 1'b1;
            end
            default: st <= PS_IDLE;
         endcase
      end
   end

   assign spi_start = (st == PS_ISSUE);
   assign busy      = (st != PS_IDLE);

   // R5: the transfer start is a single-cycle pulse
   a_r5_start_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |=> !spi_start);

   // R8: the error flag is only ever raised out of an active poll
   a_r8_err_from_busy : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_err) |-> $past(busy));

   // R6: a ready status ends the poll on the next edge
   a_r6_ready_ends : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && busy && !spi_start && spi_done && spi_rdata[READY_BIT] && !$past(spi_start)) |=> !busy);

endmodule

// File: rtl/fpwr_seq_top.sv
module fpwr_seq_top
   import fpwr_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 125_000_000,
   parameter int unsigned SEL_DELAY_NS = 50_000,
   parameter int unsigned WR_DELAY_NS  = 20_000_000,
   parameter int unsigned POLL_GAP     = 64,
   parameter int unsigned TMO_CYC      = 2_000_000,
   parameter logic [7:0]  STATUS_CMD   = 8'h05,
   parameter bit          SHARED_TIMER = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       op_req,
   input  logic       op_is_write,
   output logic       op_grant,
   input  logic       op_done,
   output logic       rd_permit,
   output logic       wr_permit,
   output logic       busy,
   output logic       tmo_err,
   output logic       spi_start,
   output logic [7:0] spi_cmd,
   input  logic       spi_done,
   input  logic [7:0] spi_rdata
);

   localparam int unsigned SEL_CYC = int'(ns_to_cycles(CLK_HZ, SEL_DELAY_NS));
   localparam int unsigned WR_CYC  = int'(ns_to_cycles(CLK_HZ, WR_DELAY_NS));
   localparam int unsigned WR_W    = $clog2(WR_CYC + 1);
   localparam int unsigned READY_BIT = 7;

   generate
      if (SEL_CYC < 1) begin : g_bad_sel
         $error("fpwr_seq_top: select delay rounds to zero cycles");
      end
      if (WR_CYC < SEL_CYC) begin : g_bad_order
         $error("fpwr_seq_top: write delay must not be shorter than select delay");
      end
   endgenerate

   // power-up permits
   generate
      if (SHARED_TIMER) begin : g_shared
         logic [WR_W-1:0] cnt;
         logic            wr_exp;
         fpwr_wait_timer #(.LIMIT(WR_CYC)) u_tmr (
            .clk(clk), .rst_n(rst_n), .run(supply_ok), .count(cnt), .expired(wr_exp));
         assign rd_permit = supply_ok && (cnt >= WR_W'(SEL_CYC));
         assign wr_permit = wr_exp;
      end else begin : g_split
         localparam int unsigned SEL_W = $clog2(SEL_CYC + 1);
         logic [SEL_W-1:0] cnt_s;
         logic [WR_W-1:0]  cnt_w;
         fpwr_wait_timer #(.LIMIT(SEL_CYC)) u_sel (
            .clk(clk), .rst_n(rst_n), .run(supply_ok), .count(cnt_s), .expired(rd_permit));
         fpwr_wait_timer #(.LIMIT(WR_CYC)) u_wr (
            .clk(clk), .rst_n(rst_n), .run(supply_ok), .count(cnt_w), .expired(wr_permit));
      end
   endgenerate

   // grant handshake
   logic gnt_q;
   logic gnt_wr_q;
   logic poll_busy;
   logic poll_start;
   logic permit_ok;

   assign permit_ok  = op_is_write ? wr_permit : rd_permit;
   assign poll_start = gnt_q && op_done && gnt_wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !supply_ok) begin
         gnt_q    <= 1'b0;
         gnt_wr_q <= 1'b0;
      end else if (gnt_q) begin
         if (op_done)
            gnt_q <= 1'b0;
      end else if (op_req && permit_ok && !poll_busy) begin
         gnt_q    <= 1'b1;
         gnt_wr_q <= op_is_write;
      end
   end

   fpwr_status_poll #(
      .GAP_CYC(POLL_GAP), .TMO_CYC(TMO_CYC), .READY_BIT(READY_BIT)
   ) u_poll (
      .clk(clk), .rst_n(rst_n), .enable(supply_ok), .start(poll_start),
      .spi_done(spi_done), .spi_rdata(spi_rdata),
      .spi_start(spi_start), .busy(poll_busy), .tmo_err(tmo_err));

   assign op_grant = gnt_q;
   assign busy     = poll_busy;
   assign spi_cmd  = STATUS_CMD;

   // R3: supply loss clears grant and poll on the next edge
   a_r3_off_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!op_grant && !busy && !tmo_err));

   // R7: never granted while a poll runs
   a_r7_no_grant_busy : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !op_grant);

   // R2: write permission implies read permission
   a_r2_wr_after_rd : assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit |-> rd_permit);

   // R4: a new grant is always backed by the read permission
   a_r4_grant_permit : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_grant) |-> $past(rd_permit));

endmodule

// File: tb/tb_fpwr_seq_top.sv
module tb_fpwr_seq_top;

   localparam int unsigned HZ      = 125_000_000;
   localparam int unsigned SEL_NS  = 404;
   localparam int unsigned WR_NS   = 1000;
   localparam int unsigned GAP     = 4;
   localparam int unsigned TMO     = 150;
   localparam logic [7:0]  CMD     = 8'h05;

   function automatic int ceil_cyc(longint unsigned hz, longint unsigned ns);
      longint unsigned p;
      p = hz * ns;
      return int'((p / 1_000_000_000) + ((p % 1_000_000_000) != 0 ? 1 : 0));
   endfunction

   localparam int SEL_EXP = ceil_cyc(HZ, SEL_NS);
   localparam int WR_EXP  = ceil_cyc(HZ, WR_NS);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b0;
   logic       op_req = 1'b0;
   logic       op_is_write = 1'b0;
   logic       op_done = 1'b0;
   logic       spi_done = 1'b0;
   logic [7:0] spi_rdata = 8'h00;
   logic       op_grant, rd_permit, wr_permit, busy, tmo_err, spi_start;
   logic [7:0] spi_cmd;

   int n_cmp = 0;
   int n_bad = 0;
   int busy_left = 0;
   int polls = 0;
   bit gap_armed = 1'b0;
   int since = 0;
   bit ended = 1'b0;

   always #4 clk = ~clk;

   fpwr_seq_top #(
      .CLK_HZ(HZ), .SEL_DELAY_NS(SEL_NS), .WR_DELAY_NS(WR_NS),
      .POLL_GAP(GAP), .TMO_CYC(TMO), .STATUS_CMD(CMD), .SHARED_TIMER(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .op_req(op_req),
      .op_is_write(op_is_write), .op_grant(op_grant), .op_done(op_done),
      .rd_permit(rd_permit), .wr_permit(wr_permit), .busy(busy), .tmo_err(tmo_err),
      .spi_start(spi_start), .spi_cmd(spi_cmd), .spi_done(spi_done), .spi_rdata(spi_rdata));

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // status-read model: busy_left not-ready bytes, then ready
   initial begin
      forever begin
         @(negedge clk);
         if (gap_armed) since++;
         if (spi_start) begin
            chk("R5 status opcode", int'(spi_cmd), int'(CMD));
            if (gap_armed) chk("R6 poll gap", since, int'(GAP));
            gap_armed = 1'b0;
            polls++;
            repeat (1 + ($urandom % 3)) @(negedge clk);
            spi_done = 1'b1;
            if (busy_left > 0) begin
               spi_rdata = 8'($urandom) & 8'h7F;
               busy_left--;
               @(negedge clk);
               spi_done = 1'b0;
               gap_armed = 1'b1;
               since = 0;
            end else begin
               spi_rdata = 8'h80 | (8'($urandom) & 8'h7F);
               @(negedge clk);
               spi_done = 1'b0;
            end
         end
      end
   end

   task automatic start_op(input bit wr, input int nbusy);
      repeat (5) @(negedge clk);
      gap_armed = 1'b0;
      busy_left = nbusy;
      polls = 0;
      op_req = 1'b1;
      op_is_write = wr;
      @(negedge clk);
      chk("R4 grant after request", int'(op_grant), 1);
      op_req = 1'b0;
      repeat ($urandom % 3) begin
         @(negedge clk);
         chk("R4 grant held", int'(op_grant), 1);
      end
   endtask

   task automatic finish_op(input bit wr, input int nbusy);
      int guard;
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
      chk("R4 grant released", int'(op_grant), 0);
      if (wr) begin
         chk("R5 busy after write", int'(busy), 1);
         op_req = 1'b1;
         op_is_write = 1'b0;
         guard = 0;
         while (busy && guard < 5000) begin
            chk("R7 no grant while busy", int'(op_grant), 0);
            @(negedge clk);
            guard++;
         end
         chk("R7 no grant at busy end", int'(op_grant), 0);
         op_req = 1'b0;
         chk("R6 status reads", polls, nbusy + 1);
         chk("R6 no timeout", int'(tmo_err), 0);
      end else begin
         chk("R9 read no busy", int'(busy), 0);
         repeat (4) @(negedge clk);
         chk("R9 read no poll", polls, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int cnt;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 reset grant", int'(op_grant), 0);
      chk("R3 reset rd_permit", int'(rd_permit), 0);
      chk("R3 reset wr_permit", int'(wr_permit), 0);
      chk("R3 reset busy", int'(busy), 0);
      chk("R3 reset tmo_err", int'(tmo_err), 0);
      chk("R5 reset spi_start", int'(spi_start), 0);

      // power-up ramp with an early write request held off
      supply_ok = 1'b1;
      for (int i = 1; i <= WR_EXP; i++) begin
         @(negedge clk);
         if (i == SEL_EXP - 1 || i == SEL_EXP || i == SEL_EXP + 1)
            chk("R1 read permit timing", int'(rd_permit), int'(i >= SEL_EXP));
         if (i == WR_EXP - 1 || i == WR_EXP)
            chk("R2 write permit timing", int'(wr_permit), int'(i >= WR_EXP));
         if (i > SEL_EXP + 2)
            chk("R4 write held before permit", int'(op_grant), 0);
         if (i == SEL_EXP + 2) begin
            op_req = 1'b1;
            op_is_write = 1'b1;
         end
      end
      busy_left = 2;
      polls = 0;
      gap_armed = 1'b0;
      @(negedge clk);
      chk("R4 write granted after permit", int'(op_grant), 1);
      op_req = 1'b0;
      finish_op(1'b1, 2);

      // directed read
      start_op(1'b0, 0);
      finish_op(1'b0, 0);

      // timeout
      start_op(1'b1, 100000);
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
      cnt = 0;
      while (busy && cnt < 5000) begin
         cnt++;
         @(negedge clk);
      end
      chk("R8 busy length at timeout", cnt, int'(TMO));
      chk("R8 error raised", int'(tmo_err), 1);
      start_op(1'b0, 0);
      finish_op(1'b0, 0);
      chk("R8 error sticky", int'(tmo_err), 1);

      // supply loss mid-poll
      start_op(1'b1, 100000);
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
      repeat (3) @(negedge clk);
      supply_ok = 1'b0;
      #1;
      chk("R3 rd_permit on loss", int'(rd_permit), 0);
      chk("R3 wr_permit on loss", int'(wr_permit), 0);
      @(negedge clk);
      chk("R3 busy cleared", int'(busy), 0);
      chk("R3 error cleared", int'(tmo_err), 0);
      op_req = 1'b1;
      op_is_write = 1'b0;
      repeat (5) begin
         @(negedge clk);
         chk("R3 no grant while off", int'(op_grant), 0);
      end
      op_req = 1'b0;
      busy_left = 0;
      supply_ok = 1'b1;
      repeat (WR_EXP + 2) @(negedge clk);
      chk("R2 write permit restored", int'(wr_permit), 1);

      // random operations
      for (int k = 0; k < 30; k++) begin
         bit wr;
         int nb;
         wr = 1'($urandom % 2);
         nb = int'($urandom % 5);
         start_op(wr, wr ? nb : 0);
         finish_op(wr, wr ? nb : 0);
      end

      summary();
   end

endmodule